// File: doc/BRIEF.md
# Programmable Sample Clock and Trigger Generator

This block produces a sample clock from one of four internal source oscillators, or from an external source, divided by a power of two between 2 and 16. It also produces a pretrigger and an event trigger. Everything is modelled synchronously. Each source oscillator is a one-cycle tick input sampled on the system clock. The block returns a one-hot enable for each internal source, so every oscillator except the selected one can be switched off.

A host programs the block through a plain write port (address, data and strobe). A write to the frequency register selects the source and the divide ratio. The divider then restarts from zero with its output held low, and a trigger sequence is armed. At the first rising edge of the new output clock the pretrigger goes high for one full output period. At the next rising edge the event trigger takes over for one period. A second register sets the high time of the output clock, counted in selected-source ticks, so the clock can be asymmetric.

Top module: `sample_clk_gen`

## Requirements
- R1: After reset, `clk_out`, `pretrig` and `trig` are low. `src_en` is 4'b0001, because source 0 divided by 2 is selected and the high time is 1.
- R2: `src_en` is one-hot on the internal source numbered by frequency-register bits [1:0]. When frequency-register bit 2 (external select) is 1, `src_en` is all zero.
- R3: The output period is 2^(c+1) selected ticks, where c is frequency-register bits [4:3]. `clk_out` changes only on the cycle after a selected tick, or on the cycle after a restart.
- R4: `clk_out` is high for H selected ticks of each period. H is duty-register (address 1) bits [3:0], clamped to at least 1 and at most the ratio minus 1.
- R5: One cycle after a write to address 0, the divider restarts with `clk_out` low. The next selected tick makes `clk_out` rise.
- R6: `pretrig` rises together with the first `clk_out` rising edge after a frequency write. It stays high for exactly one output period.
- R7: `trig` rises on the `clk_out` rising edge where `pretrig` falls. It stays high for one output period and is never high together with `pretrig`.
- R8: A write to address 1 changes only the high time and fires no trigger. Writes to addresses 2 and 3 have no effect.
- R9: Ticks on internal sources that are not selected, and ticks on the external input while an internal source is selected, have no effect.
- R10: A frequency write while a trigger sequence is still in progress cancels that sequence and arms a new one from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 frequency, 1 duty, 2 and 3 unused |
| wr_data | input | 5 | Write data |
| src_tick | input | 4 | One-cycle ticks of the four internal source oscillators |
| ext_tick | input | 1 | One-cycle tick of the external source |
| src_en | output | 4 | One-hot enable of the selected internal source |
| clk_out | output | 1 | Divided, duty-shaped sample clock |
| pretrig | output | 1 | Pretrigger, one output period wide |
| trig | output | 1 | Event trigger, one output period wide |

## Verification
The checker watches every cycle for the following:
- `src_en` is one-hot or zero.
- `clk_out` moves only after a selected tick or a restart, and is low after a restart.
- `pretrig` and `trig` start on a `clk_out` rising edge, follow one another, and never overlap.

The exact period, the clamped high time, ignored writes and deselected sources cannot be seen by a local property. The bench shows them by comparing every output, every cycle, against a model built from the requirements. It runs directed clamp, external-source, ignored-address and mid-sequence-rewrite scenarios, plus random writes and ticks.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  parameter int SRC_N  = 4;  // internal source oscillators
  parameter int DIV_N  = 4;  // number of power-of-two divide codes
  localparam int SRC_W  = $clog2(SRC_N);
  localparam int DIVC_W = $clog2(DIV_N);
  localparam int CNT_W  = DIV_N;              // phase counter width, max ratio 2^DIV_N
  localparam int CFG_W  = DIVC_W + 1 + SRC_W;
  localparam int DATA_W = CFG_W;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_FREQ = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;

  // src in the low bits, external select above, divide code on top
  typedef struct packed {
    logic [DIVC_W-1:0] div;
    logic              ext;
    logic [SRC_W-1:0]  src;
  } freq_cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_PRE   = 2'd2,
    SEQ_TRIG  = 2'd3
  } seq_t;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output freq_cfg_t         cfg,
  output logic [CNT_W-1:0]  duty,
  output logic              launch
);
  freq_cfg_t        cfg_nxt;
  logic [CNT_W-1:0] duty_nxt;
  logic             launch_nxt;

  always_comb begin
    cfg_nxt    = cfg;
    duty_nxt   = duty;
    launch_nxt = 1'b0;
    if (wr_en && wr_addr == ADDR_FREQ) begin
      cfg_nxt    = freq_cfg_t'(wr_data[CFG_W-1:0]);
      launch_nxt = 1'b1;
    end
    if (wr_en && wr_addr == ADDR_DUTY)
      duty_nxt = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      duty   <= '0;
      launch <= 1'b0;
    end else begin
      cfg    <= cfg_nxt;
      duty   <= duty_nxt;
      launch <= launch_nxt;
    end
  end
endmodule

// File: rtl/clkgen_srcsel.sv
module clkgen_srcsel
  import clkgen_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  logic             ext,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             ext_tick,
  output logic [SRC_N-1:0] src_en,
  output logic             sel_tick
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_gate
    assign src_en[i] = !ext && (src == SRC_W'(i));
  end

  assign sel_tick = ext ? ext_tick : |(src_tick & src_en);
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  logic [DIVC_W-1:0] div,
  input  logic [CNT_W-1:0]  duty,
  output logic              clk_out,
  output logic              rise
);
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] hi;
  logic [CNT_W-1:0] ph, ph_nxt;
  logic             out_nxt;

  assign ratio = (CNT_W+1)'(2) << div;
  assign last  = CNT_W'(ratio - 1'b1);

  always_comb begin
    if (duty == '0)       hi = CNT_W'(1);
    else if (duty > last) hi = last;
    else                  hi = duty;
  end

  assign rise = tick && !launch && (ph == last);

  always_comb begin
    ph_nxt  = ph;
    out_nxt = clk_out;
    if (launch) begin
      ph_nxt  = last;
      out_nxt = 1'b0;
    end else if (tick) begin
      ph_nxt  = (ph == last) ? '0 : ph + 1'b1;
      out_nxt = (ph_nxt < hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= CNT_W'(1);
      clk_out <= 1'b0;
    end else begin
      ph      <= ph_nxt;
      clk_out <= out_nxt;
    end
  end
endmodule

// File: rtl/clkgen_seq.sv
module clkgen_seq
  import clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic rise,
  output logic pretrig,
  output logic trig
);
  seq_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (launch) st_nxt = SEQ_ARMED;
    else if (rise) begin
      case (st)
        SEQ_ARMED: st_nxt = SEQ_PRE;
        SEQ_PRE:   st_nxt = SEQ_TRIG;
        SEQ_TRIG:  st_nxt = SEQ_IDLE;
        default:   st_nxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEQ_IDLE;
    else        st <= st_nxt;
  end

  assign pretrig = (st == SEQ_PRE);
  assign trig    = (st == SEQ_TRIG);
endmodule

// File: rtl/sample_clk_gen.sv
module sample_clk_gen
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SRC_N-1:0]  src_tick,
  input  logic              ext_tick,
  output logic [SRC_N-1:0]  src_en,
  output logic              clk_out,
  output logic              pretrig,
  output logic              trig
);
  logic [1:0]       rst_q;
  logic             rst_sync_n;
  freq_cfg_t        cfg;
  logic [CNT_W-1:0] duty;
  logic             launch;
  logic             sel_tick;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  clkgen_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .duty(duty), .launch(launch)
  );

  clkgen_srcsel u_srcsel (
    .src(cfg.src), .ext(cfg.ext), .src_tick(src_tick), .ext_tick(ext_tick),
    .src_en(src_en), .sel_tick(sel_tick)
  );

  clkgen_div u_div (
    .clk(clk), .rst_n(rst_sync_n), .tick(sel_tick), .launch(launch),
    .div(cfg.div), .duty(duty), .clk_out(clk_out), .rise(rise)
  );

  clkgen_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .launch(launch), .rise(rise),
    .pretrig(pretrig), .trig(trig)
  );
endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker
  import clkgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] src_en,
  input logic             sel_tick,
  input logic             launch,
  input logic             clk_out,
  input logic             pretrig,
  input logic             trig
);
  p_src_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_en));

  p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(sel_tick));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel_tick) && !$past(launch)) |-> $stable(clk_out));

  p_restart_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !clk_out);

  p_pre_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pretrig) |-> $rose(clk_out));

  p_trig_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pretrig) && !$past(launch)) |-> ($rose(trig) && $rose(clk_out)));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pretrig && trig));
endmodule

bind sample_clk_gen clkgen_checker i_chk (
  .clk(clk), .rst_n(rst_sync_n), .src_en(src_en), .sel_tick(sel_tick),
  .launch(launch), .clk_out(clk_out), .pretrig(pretrig), .trig(trig)
);

// File: tb/test_sample_clk_gen.sv
module test_sample_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [4:0] wr_data = 5'd0;
  logic [3:0] src_tick = 4'd0;
  logic       ext_tick = 1'b0;
  logic [3:0] src_en;
  logic       clk_out, pretrig, trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R3";

  // reference model state
  int m_src = 0, m_div = 0, m_duty = 0, m_ph = 1, m_seq = 0;
  bit m_ext = 0, m_out = 0, m_launch = 0;
  int ignore_tick_mask = 0;

  always #2.5 clk = ~clk;

  sample_clk_gen i_sample_clk_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_tick(src_tick), .ext_tick(ext_tick), .src_en(src_en),
    .clk_out(clk_out), .pretrig(pretrig), .trig(trig)
  );

  function automatic int ratio_of(int d);
    return 2 << d;
  endfunction

  function automatic int high_of(int duty, int r);
    if (duty < 1) return 1;
    if (duty > r - 1) return r - 1;
    return duty;
  endfunction

  function automatic logic [3:0] exp_en();
    return m_ext ? 4'd0 : 4'(1 << m_src);
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", what, tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int r, h, nph;
    bit tk;
    r  = ratio_of(m_div);
    h  = high_of(m_duty, r);
    tk = m_ext ? ext_tick : src_tick[m_src];
    if (m_launch) begin
      m_ph = r - 1; m_out = 0; m_seq = 1;
    end else if (tk) begin
      nph = (m_ph == r - 1) ? 0 : m_ph + 1;
      if (nph == 0) m_seq = (m_seq == 1) ? 2 : (m_seq == 2) ? 3 : 0;
      m_ph = nph; m_out = (nph < h);
    end
    m_launch = wr_en && wr_addr == 2'd0;
    if (wr_en && wr_addr == 2'd0) begin
      m_src = int'(wr_data[1:0]); m_ext = wr_data[2]; m_div = int'(wr_data[4:3]);
    end
    if (wr_en && wr_addr == 2'd1) m_duty = int'(wr_data[3:0]);
  endtask

  task automatic compare_all();
    chk({3'd0, clk_out}, {3'd0, m_out}, "R3 R4 R5 clk_out");
    chk(src_en, exp_en(), "R2 src_en");
    chk({3'd0, pretrig}, {3'd0, m_seq == 2}, "R6 pretrig");
    chk({3'd0, trig}, {3'd0, m_seq == 3}, "R7 trig");
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit we, input logic [1:0] a, input logic [4:0] d,
                      input logic [3:0] st, input bit et);
    wr_en = we; wr_addr = a; wr_data = d; src_tick = st; ext_tick = et;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 2'd0, 5'd0, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    step(1'b1, a, d, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
  endtask

  initial begin
    void'($urandom(32'd1994));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk({3'd0, clk_out}, 4'd0, "R1 reset clk_out");
    chk({3'd0, pretrig}, 4'd0, "R1 reset pretrig");
    chk({3'd0, trig}, 4'd0, "R1 reset trig");
    chk(src_en, 4'b0001, "R1 reset src_en");

    tag = "R3"; run_ticks(40);
    // source 2, divide by 4: {div=1, ext=0, src=2}
    tag = "R5"; wr(2'd0, 5'b01_0_10); run_ticks(60);
    tag = "R4"; wr(2'd1, 5'd0); run_ticks(40);     // clamps to 1
    wr(2'd1, 5'd15); run_ticks(40);                // clamps to ratio-1 = 3
    tag = "R8"; wr(2'd1, 5'd2); run_ticks(30);     // duty write fires no trigger
    tag = "R2"; wr(2'd0, 5'b11_1_00); run_ticks(120); // external, divide by 16
    tag = "R8"; wr(2'd2, 5'b00_0_11); run_ticks(20);
    wr(2'd3, 5'b11_0_01); run_ticks(20);
    tag = "R9";
    wr(2'd0, 5'b00_0_01);                          // source 1 only, divide by 2
    for (int i = 0; i < 30; i++)
      step(1'b0, 2'd0, 5'd0, 4'b1101, 1'b1);       // only deselected sources tick
    run_ticks(20);
    tag = "R10";
    wr(2'd0, 5'b10_0_11); run_ticks(5);
    wr(2'd0, 5'b10_0_11); run_ticks(12);
    wr(2'd0, 5'b01_0_00); run_ticks(9);
    wr(2'd0, 5'b00_0_10); run_ticks(30);
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0)
        wr(2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)));
      else
        step(1'b0, 2'd0, 5'd0, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule